// File: doc/BRIEF.md
# Debug Trigger Chain Combiner

This block turns the raw per-trigger match bits of a processor pipeline into one debug trap decision per retired instruction slot. It keeps configuration for ten triggers, arranged as five fixed pairs. Each trigger has an enable and a timing bit, and each pair has a chain flag. The pairing rules, the timing rules and a one-deep pending register decide whether the slot traps now, whether the next valid slot traps, and which trigger caused it.

Triggers 2g and 2g+1 form pair g. The pair kinds, from pair 0 up, are: fetch+fetch, store+store, load+load, fetch+store and fetch+load. The four fetch-side triggers are 0, 1, 6 and 8. The six memory-side triggers are 2, 3, 4, 5, 7 and 9. Configuration arrives on two plain write strobes, one for each side.

The slot input has no back-pressure. The block has no ready signal and evaluates every cycle in which `slot_valid` is high. The outputs are combinational from the current slot and the registered state.

Top module: `dbg_trig_combiner`

## Requirements
- R1: After reset, every enable, timing bit and chain flag is 0 and nothing is pending. With all matches high on a valid slot, `hit`, `trap_now` and `trap_next` stay 0 and `fire_idx` is 0.
- R2: An enabled, unchained trigger qualifies on its own match. A disabled trigger never qualifies.
- R3: When the chain flag of pair g is set, neither trigger of that pair qualifies unless both are enabled and both match in the same slot.
- R4: A chained pair whose two timing bits differ never qualifies, even if both triggers match.
- R5: The chain flag of pair 1 (store+store) is ignored, so its triggers always behave as unchained.
- R6: Timing 0 means trap on the current slot (`trap_now`). A qualified timing-1 trigger sets a pending flag instead. The next valid slot then raises `trap_next`, and `fire_idx` gives the stored trigger number. Slots with `slot_valid` low neither consume nor clear the pending flag. Any valid slot clears it, unless that same slot sets it again.
- R7: `flush` clears the pending flag. A timing-1 hit in the same cycle as `flush` is dropped.
- R8: `fire_idx` reports the lowest-numbered trigger among those that produced the trap, as a 4-bit trigger number 0..9. If nothing traps, it is 0. When a slot has a timing-0 trap and a pending trap at once, `trap_now` is raised, `trap_next` stays 0 and the pending flag is consumed.
- R9: Write address decoding is as follows. Fetch-side addresses 0, 1, 2 and 3 select triggers 0, 1, 6 and 8. Memory-side addresses 0 to 5 select triggers 2, 3, 4, 5, 7 and 9. Memory-side addresses 6 and 7 change nothing. The chain field is stored only when the even trigger of a pair is written. Match bit k of `fe_match` and `mem_match` belongs to the trigger at address k of the same side.
- R10: `hit` is the OR of all qualified triggers, whatever their timing. While `slot_valid` is low, `hit` and `trap_now` are 0.
- R11: A configuration write takes effect from the cycle after its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fe_wr_valid | input | 1 | Fetch-side configuration write strobe |
| fe_wr_addr | input | 2 | Fetch-side trigger address |
| fe_wr_enable | input | 1 | Enable value to write |
| fe_wr_timing | input | 1 | Timing value to write (0 now, 1 next) |
| fe_wr_chain | input | 1 | Chain value to write (stored for even triggers) |
| mem_wr_valid | input | 1 | Memory-side configuration write strobe |
| mem_wr_addr | input | 3 | Memory-side trigger address |
| mem_wr_enable | input | 1 | Enable value to write |
| mem_wr_timing | input | 1 | Timing value to write |
| mem_wr_chain | input | 1 | Chain value to write |
| slot_valid | input | 1 | A retired instruction slot is presented |
| fe_match | input | 4 | Raw fetch-side match bits |
| mem_match | input | 6 | Raw memory-side match bits |
| flush | input | 1 | Pipeline flush, drops the pending trap |
| hit | output | 1 | Some trigger qualified in this slot |
| trap_now | output | 1 | Trap on the current slot |
| trap_next | output | 1 | Trap on this slot, owed by an earlier timing-1 hit |
| fire_idx | output | 4 | Number of the trigger behind the trap |

## Verification
Two functions can fall in the same cycle: a timing-0 trap and the release of a pending timing-1 trap. The bench provokes this by qualifying trigger 8 (timing 1) and then matching trigger 0 on the next slot. It expects `trap_now` high, `trap_next` low and index 0, and it checks that no trap is still owed on the following slot. A second overlap is a configuration write and a match in the same cycle. The bench judges that case by the old configuration holding for that cycle and the new one holding from the next.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  localparam int TRIG_N    = 10;
  localparam int GRP_N     = TRIG_N / 2;
  localparam int FE_N      = 4;
  localparam int MEM_N     = TRIG_N - FE_N;
  localparam int FE_AW     = $clog2(FE_N);
  localparam int MEM_AW    = $clog2(MEM_N);
  localparam int IDX_W     = $clog2(TRIG_N);
  localparam int STORE_GRP = 1;

  function automatic int fe_trig(int k);
    case (k)
      0:       return 0;
      1:       return 1;
      2:       return 6;
      default: return 8;
    endcase
  endfunction

  function automatic int mem_trig(int k);
    case (k)
      0:       return 2;
      1:       return 3;
      2:       return 4;
      3:       return 5;
      4:       return 7;
      default: return 9;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] lowest_set(logic [TRIG_N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = TRIG_N - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/dbg_trig_cfg.sv
module dbg_trig_cfg
  import dbg_trig_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fe_wr_valid,
  input  logic [FE_AW-1:0]     fe_wr_addr,
  input  logic                 fe_wr_enable,
  input  logic                 fe_wr_timing,
  input  logic                 fe_wr_chain,
  input  logic                 mem_wr_valid,
  input  logic [MEM_AW-1:0]    mem_wr_addr,
  input  logic                 mem_wr_enable,
  input  logic                 mem_wr_timing,
  input  logic                 mem_wr_chain,
  output logic [TRIG_N-1:0]    en_q,
  output logic [TRIG_N-1:0]    tm_q,
  output logic [GRP_N-1:0]     ch_q
);
  logic [TRIG_N-1:0] sel_fe, sel_mem;

  always_comb begin
    sel_fe  = '0;
    sel_mem = '0;
    for (int k = 0; k < FE_N; k++) begin
      if (fe_wr_valid && fe_wr_addr == FE_AW'(k)) sel_fe[fe_trig(k)] = 1'b1;
    end
    for (int k = 0; k < MEM_N; k++) begin
      if (mem_wr_valid && mem_wr_addr == MEM_AW'(k)) sel_mem[mem_trig(k)] = 1'b1;
    end
  end

  for (genvar t = 0; t < TRIG_N; t++) begin : g_trig
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q[t] <= 1'b0;
        tm_q[t] <= 1'b0;
      end else if (sel_fe[t]) begin
        en_q[t] <= fe_wr_enable;
        tm_q[t] <= fe_wr_timing;
      end else if (sel_mem[t]) begin
        en_q[t] <= mem_wr_enable;
        tm_q[t] <= mem_wr_timing;
      end
    end
  end

  for (genvar g = 0; g < GRP_N; g++) begin : g_chain
    always_ff @(posedge clk) begin
      if (!rst_n)              ch_q[g] <= 1'b0;
      else if (sel_fe[2*g])    ch_q[g] <= fe_wr_chain;
      else if (sel_mem[2*g])   ch_q[g] <= mem_wr_chain;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fe_wr_valid && !mem_wr_valid) |=> ($stable(en_q) && $stable(tm_q) && $stable(ch_q))); // R9
endmodule

// File: rtl/dbg_trig_pair.sv
module dbg_trig_pair #(
  parameter bit CHAIN_OK = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] en,
  input  logic [1:0] tm,
  input  logic       chain,
  input  logic [1:0] match,
  output logic [1:0] q
);
  logic chained, both, same;

  always_comb begin
    chained = chain & CHAIN_OK;
    both    = &(en & match);
    same    = (tm[0] == tm[1]);
    q       = chained ? {2{both & same}} : (en & match);
  end

  AST_PAIR_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ((q & ~en) == 2'b00)); // R2
  AST_PAIR_JOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (chain && CHAIN_OK) |-> (q[0] == q[1])); // R3
  AST_PAIR_SKEW: assert property (@(posedge clk) disable iff (!rst_n)
    (chain && CHAIN_OK && tm[0] != tm[1]) |-> (q == 2'b00)); // R4
  AST_PAIR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!CHAIN_OK && chain && (en & match) == 2'b01) |-> (q == 2'b01)); // R5
endmodule

// File: rtl/dbg_trig_pend.sv
module dbg_trig_pend
  import dbg_trig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_valid,
  input  logic              flush,
  input  logic [TRIG_N-1:0] now_vec,
  input  logic [TRIG_N-1:0] next_vec,
  output logic              trap_now,
  output logic              trap_next,
  output logic [IDX_W-1:0]  fire_idx
);
  logic             pend_q;
  logic [IDX_W-1:0] pend_idx_q;
  logic             now_any, set_req;

  always_comb begin
    now_any   = |now_vec;
    set_req   = slot_valid & (|next_vec);
    trap_now  = now_any;
    trap_next = slot_valid & pend_q & ~now_any;
    if (trap_now)       fire_idx = lowest_set(now_vec);
    else if (trap_next) fire_idx = pend_idx_q;
    else                fire_idx = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
    end else if (flush) begin
      pend_q     <= 1'b0;
    end else if (set_req) begin
      pend_q     <= 1'b1;
      pend_idx_q <= lowest_set(next_vec);
    end else if (slot_valid) begin
      pend_q     <= 1'b0;
    end
  end

  AST_NOW_BEATS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_now && trap_next)); // R8
  AST_PEND_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && pend_q && next_vec == '0) |=> !pend_q); // R6
  AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pend_q); // R7
endmodule

// File: rtl/dbg_trig_combiner.sv
module dbg_trig_combiner
  import dbg_trig_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fe_wr_valid,
  input  logic [FE_AW-1:0]  fe_wr_addr,
  input  logic              fe_wr_enable,
  input  logic              fe_wr_timing,
  input  logic              fe_wr_chain,
  input  logic              mem_wr_valid,
  input  logic [MEM_AW-1:0] mem_wr_addr,
  input  logic              mem_wr_enable,
  input  logic              mem_wr_timing,
  input  logic              mem_wr_chain,
  input  logic              slot_valid,
  input  logic [FE_N-1:0]   fe_match,
  input  logic [MEM_N-1:0]  mem_match,
  input  logic              flush,
  output logic              hit,
  output logic              trap_now,
  output logic              trap_next,
  output logic [IDX_W-1:0]  fire_idx
);
  logic [TRIG_N-1:0] en_q, tm_q, m, q, qv, now_vec, next_vec;
  logic [GRP_N-1:0]  ch_q;

  dbg_trig_cfg u_cfg (
    .clk, .rst_n,
    .fe_wr_valid, .fe_wr_addr, .fe_wr_enable, .fe_wr_timing, .fe_wr_chain,
    .mem_wr_valid, .mem_wr_addr, .mem_wr_enable, .mem_wr_timing, .mem_wr_chain,
    .en_q, .tm_q, .ch_q
  );

  for (genvar k = 0; k < FE_N; k++) begin : g_fe_map
    localparam int T = fe_trig(k);
    assign m[T] = fe_match[k];
  end
  for (genvar k = 0; k < MEM_N; k++) begin : g_mem_map
    localparam int T = mem_trig(k);
    assign m[T] = mem_match[k];
  end

  for (genvar g = 0; g < GRP_N; g++) begin : g_pair
    dbg_trig_pair #(.CHAIN_OK(g != STORE_GRP)) u_pair (
      .clk, .rst_n,
      .en    (en_q[2*g+1 -: 2]),
      .tm    (tm_q[2*g+1 -: 2]),
      .chain (ch_q[g]),
      .match (m[2*g+1 -: 2]),
      .q     (q[2*g+1 -: 2])
    );
  end

  always_comb begin
    qv       = q & {TRIG_N{slot_valid}};
    now_vec  = qv & ~tm_q;
    next_vec = qv & tm_q;
    hit      = |qv;
  end

  dbg_trig_pend u_pend (
    .clk, .rst_n, .slot_valid, .flush,
    .now_vec, .next_vec,
    .trap_now, .trap_next, .fire_idx
  );

  AST_IDLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_valid |-> !(hit || trap_now)); // R10
endmodule

// File: tb/test_dbg_trig_combiner.sv
`timescale 1ns/1ps
module test_dbg_trig_combiner;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fe_wr_valid = 0, fe_wr_enable = 0, fe_wr_timing = 0, fe_wr_chain = 0;
  logic [1:0] fe_wr_addr = '0;
  logic mem_wr_valid = 0, mem_wr_enable = 0, mem_wr_timing = 0, mem_wr_chain = 0;
  logic [2:0] mem_wr_addr = '0;
  logic slot_valid = 0, flush = 0;
  logic [3:0] fe_match = '0;
  logic [5:0] mem_match = '0;
  logic hit, trap_now, trap_next;
  logic [3:0] fire_idx;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dbg_trig_combiner i_dbg_trig_combiner (.*);

  // row: fe_match, mem_match, hit, trap_now, fire_idx
  localparam logic [15:0] TBL [13] = '{
    {4'b0001, 6'b000000, 1'b1, 1'b1, 4'd0},
    {4'b0010, 6'b000000, 1'b1, 1'b1, 4'd1},
    {4'b0011, 6'b000000, 1'b1, 1'b1, 4'd0},
    {4'b0000, 6'b000001, 1'b1, 1'b1, 4'd2},
    {4'b0000, 6'b000010, 1'b1, 1'b1, 4'd3},
    {4'b0000, 6'b000100, 1'b0, 1'b0, 4'd0},
    {4'b0000, 6'b001000, 1'b0, 1'b0, 4'd0},
    {4'b0000, 6'b001100, 1'b1, 1'b1, 4'd4},
    {4'b0100, 6'b010000, 1'b0, 1'b0, 4'd0},
    {4'b0000, 6'b100000, 1'b0, 1'b0, 4'd0},
    {4'b0100, 6'b000000, 1'b0, 1'b0, 4'd0},
    {4'b0000, 6'b001110, 1'b1, 1'b1, 4'd3},
    {4'b0000, 6'b000000, 1'b0, 1'b0, 4'd0}
  };

  task automatic check(string req, logic [6:0] exp);
    logic [6:0] act;
    act = {hit, trap_now, trap_next, fire_idx};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {hit,now,next,idx} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(logic [3:0] fe, logic [5:0] mm, logic v, logic fl,
                      logic [6:0] exp, string req);
    @(negedge clk);
    fe_match = fe; mem_match = mm; slot_valid = v; flush = fl;
    #1 check(req, exp);
  endtask

  task automatic wr_fe(logic [1:0] a, logic e, logic t, logic c);
    @(negedge clk);
    slot_valid = 0; fe_wr_valid = 1; fe_wr_addr = a;
    fe_wr_enable = e; fe_wr_timing = t; fe_wr_chain = c;
    @(negedge clk) fe_wr_valid = 0;
  endtask

  task automatic wr_mem(logic [2:0] a, logic e, logic t, logic c);
    @(negedge clk);
    slot_valid = 0; mem_wr_valid = 1; mem_wr_addr = a;
    mem_wr_enable = e; mem_wr_timing = t; mem_wr_chain = c;
    @(negedge clk) mem_wr_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1: cleared configuration, every match high
    step(4'hF, 6'h3F, 1, 0, 7'b000_0000, "R1 reset state");
    step(4'h0, 6'h00, 1, 0, 7'b000_0000, "R1 nothing pending");

    // R11: write and match in the same cycle
    @(negedge clk);
    fe_wr_valid = 1; fe_wr_addr = 2'd0; fe_wr_enable = 1; fe_wr_timing = 0; fe_wr_chain = 0;
    fe_match = 4'b0001; slot_valid = 1;
    #1 check("R11 old config during write", 7'b000_0000);
    @(negedge clk) fe_wr_valid = 0;
    #1 check("R11 new config next cycle", 7'b110_0000);

    // full configuration (R9 mapping)
    wr_fe (2'd1, 1, 0, 0);  // t1
    wr_mem(3'd0, 1, 0, 1);  // t2, chain on store pair
    wr_mem(3'd1, 1, 0, 0);  // t3
    wr_mem(3'd2, 1, 0, 1);  // t4, chain pair 2
    wr_mem(3'd3, 1, 0, 0);  // t5
    wr_fe (2'd2, 1, 0, 1);  // t6, chain pair 3
    wr_mem(3'd4, 1, 1, 0);  // t7, timing 1
    wr_fe (2'd3, 1, 1, 0);  // t8, timing 1
    wr_mem(3'd5, 0, 0, 0);  // t9 disabled

    for (int i = 0; i < 13; i++) begin
      step(TBL[i][15:12], TBL[i][11:6], 1, 0,
           {TBL[i][5], TBL[i][4], 1'b0, TBL[i][3:0]}, $sformatf("R2/R3/R4/R5/R8 row %0d", i));
    end

    // R9: memory addresses 6 and 7 alter nothing
    wr_mem(3'd6, 1, 1, 1);
    wr_mem(3'd7, 1, 1, 1);
    step(4'b0000, 6'b100000, 1, 0, 7'b000_0000, "R9 t9 still disabled");
    step(4'b0100, 6'b010000, 1, 0, 7'b000_0000, "R9 t7 timing unchanged");
    step(4'b0000, 6'b000001, 1, 0, 7'b110_0010, "R9 t2 intact");

    // R6: pending trap waits for the next valid slot
    step(4'b1000, 6'b0, 1, 0, 7'b100_0000, "R6 timing-1 hit");
    step(4'b0000, 6'b0, 0, 0, 7'b000_0000, "R6 idle slot keeps pending");
    step(4'b0000, 6'b0, 1, 0, 7'b001_1000, "R6 trap_next idx 8");
    step(4'b0000, 6'b0, 1, 0, 7'b000_0000, "R6 pending cleared");

    // R8: trap-now wins over pending
    step(4'b1000, 6'b0, 1, 0, 7'b100_0000, "R8 set pending");
    step(4'b0001, 6'b0, 1, 0, 7'b110_0000, "R8 now beats next");
    step(4'b0000, 6'b0, 1, 0, 7'b000_0000, "R8 pending consumed");
    step(4'b1000, 6'b001100, 1, 0, 7'b110_0100, "R8 chained pair plus t8");
    step(4'b0000, 6'b0, 1, 0, 7'b001_1000, "R8 deferred t8 follows");

    // R7: flush drops pending
    step(4'b1000, 6'b0, 1, 0, 7'b100_0000, "R7 set pending");
    step(4'b0000, 6'b0, 0, 1, 7'b000_0000, "R7 flush cycle");
    step(4'b0000, 6'b0, 1, 0, 7'b000_0000, "R7 no trap after flush");
    step(4'b1000, 6'b0, 1, 1, 7'b100_0000, "R7 hit with flush");
    step(4'b0000, 6'b0, 1, 0, 7'b000_0000, "R7 hit during flush dropped");

    // R10: invalid slot
    step(4'b0001, 6'b001100, 0, 0, 7'b000_0000, "R10 slot_valid low");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule